// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the single 32-bit control and status word for the one root port of a USB host controller. Status that the port layer reports (device attached, overcurrent, data-line levels, attached-device speed) is captured into read-only bits. Each of the three event sources (attach, enable, overcurrent) has a sticky change flag that software acknowledges by writing 1. Software owns the power, reset, suspend and resume controls, and these drive the port layer directly.

The enable bit is set only by hardware. A small state machine moves the port between three states, `ST_OFF`, `ST_RESET` and `ST_ON`. `ST_OFF` goes to `ST_RESET` when the reset control is 1. `ST_RESET` goes to `ST_ON` when the reset control is cleared while a device is attached. `ST_RESET` goes back to `ST_OFF` when the reset control is cleared with no device attached. `ST_ON` goes to `ST_OFF` on detach, on a new overcurrent, on power removal or on a software disable. `ST_ON` goes to `ST_RESET` when the reset control is set again. Writing 1 to the enable bit disables the port. Software must therefore write 0 to the enable bit and to every change flag it does not mean to touch.

A single interrupt request goes to the interrupt logic. It is high while any change flag is set.

Top module: `rootport_csr`

## Requirements
- R1: After reset, `csr_rdata` is 0 and `port_power`, `port_reset`, `port_suspend`, `port_resume`, `port_enabled` and `port_change_irq` are all 0.
- R2: Bit 0 shows `phy_connected` one clock later, and writes to it are ignored. Bit 1 is set on every change of bit 0 and is cleared by writing 1 to bit 1. When a set and a clear fall in the same cycle, the flag stays set.
- R3: Bit 2 (`port_enabled`) is 1 only in state `ST_ON`, and it is never 1 while bit 0 is 0.
- R4: Writing 1 to bit 2 while the port is enabled disables it and sets bit 3. Writing 0 to bit 2 has no effect.
- R5: Bit 4 shows `phy_overcurrent` one clock later and is read-only. Bit 5 is set on every change of bit 4 and is cleared by writing 1 to bit 5. A rising overcurrent disables an enabled port.
- R6: Bits 6 (resume), 7 (suspend), 8 (reset) and 12 (power) are read/write. They read back what was written and drive `port_resume`, `port_suspend`, `port_reset` and `port_power`. Clearing bit 12 while the port is enabled disables the port.
- R7: Bits 11:10 show the line levels (bit 10 = D+, bit 11 = D-). Bits 18:17 show the speed (00 high, 01 full, 10 low) and read 00 while bit 0 is 0. Bits 9, 16:13 and 31:19 always read 0.
- R8: `port_change_irq` is 1 exactly when at least one of bits 1, 3 and 5 is set.
- R9: Clearing bit 8 while a device is attached enables the port and sets bit 3. Clearing it with no device attached leaves the port disabled and bit 3 unchanged. Setting bit 8 while the port is enabled disables it and sets bit 3.
- R10: On a detach while the port is enabled, bits 0 and 2 clear on the same clock edge, and bits 1 and 3 are both set.
- R11: Writing 0 to bits 1, 3 or 5 never clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the status/control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current status/control word |
| phy_connected | input | 1 | Device attached, from port layer |
| phy_overcurrent | input | 1 | Overcurrent active, from port layer |
| phy_line | input | 2 | Line levels, bit 0 = D+, bit 1 = D- |
| phy_speed | input | 2 | Attached-device speed code |
| port_power | output | 1 | Port power request |
| port_reset | output | 1 | Port reset drive |
| port_suspend | output | 1 | Port suspend request |
| port_resume | output | 1 | Resume signalling request |
| port_enabled | output | 1 | Port is enabled |
| port_change_irq | output | 1 | Port change interrupt request |

## Verification
The hardest situation to reach is a detach that lands while the port is in `ST_ON`. In that case two change flags and two status bits must move on one edge. Getting there takes the full sequence: power on, hold reset, release reset with a device attached, clear the resulting enable flag, and only then drop `phy_connected`. A second hard case is a hardware set that coincides with a software clear. The bench reaches it by driving the attach change and a write of 1 to bit 1 on the same clock.

// File: rtl/rpcsr_pkg.sv
package rpcsr_pkg;

    localparam int CSR_W    = 32;
    localparam int LINE_W   = 2;
    localparam int SPEED_W  = 2;
    localparam int NUM_CHG  = 3;

    // bit positions decoded by software
    localparam int B_CONN    = 0;
    localparam int B_EN      = 2;
    localparam int B_OC      = 4;
    localparam int B_RESUME  = 6;
    localparam int B_SUSPEND = 7;
    localparam int B_PRESET  = 8;
    localparam int B_LINE    = 10;
    localparam int B_POWER   = 12;
    localparam int B_SPEED   = 17;

    // change flag indices
    localparam int CHG_CONN = 0;
    localparam int CHG_EN   = 1;
    localparam int CHG_OC   = 2;

    // every change flag sits just above its status bit
    function automatic int chg_pos(input int idx);
        return 1 + 2 * idx;
    endfunction

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RESET = 2'd1,
        ST_ON    = 2'd2
    } port_state_e;

    typedef struct packed {
        logic resume;
        logic suspend;
        logic preset;
        logic power;
    } port_ctl_t;

endpackage

// File: rtl/rpcsr_sticky.sv
module rpcsr_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/rpcsr_status_cap.sv
module rpcsr_status_cap #(
    parameter int LINE_W  = 2,
    parameter int SPEED_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phy_connected,
    input  logic               phy_overcurrent,
    input  logic [LINE_W-1:0]  phy_line,
    input  logic [SPEED_W-1:0] phy_speed,
    output logic               conn_q,
    output logic               oc_q,
    output logic [LINE_W-1:0]  line_q,
    output logic [SPEED_W-1:0] speed_q,
    output logic               conn_toggle,
    output logic               oc_toggle,
    output logic               oc_rise
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conn_q  <= 1'b0;
            oc_q    <= 1'b0;
            line_q  <= '0;
            speed_q <= '0;
        end else begin
            conn_q  <= phy_connected;
            oc_q    <= phy_overcurrent;
            line_q  <= phy_line;
            speed_q <= phy_speed;
        end
    end

    always_comb begin
        conn_toggle = conn_q ^ phy_connected;
        oc_toggle   = oc_q ^ phy_overcurrent;
        oc_rise     = phy_overcurrent & ~oc_q;
    end

endmodule

// File: rtl/rpcsr_port_fsm.sv
module rpcsr_port_fsm
    import rpcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rst_req,
    input  logic        conn_q,
    input  logic        phy_conn,
    input  logic        oc_rise,
    input  logic        power_on,
    input  logic        sw_disable,
    output logic        enabled,
    output logic        en_toggle,
    output port_state_e state_o
);

    port_state_e state, nxt;
    logic        drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        drop = ~phy_conn | oc_rise | ~power_on | sw_disable;
        nxt  = state;
        unique case (state)
            ST_OFF: begin
                if (rst_req) nxt = ST_RESET;
            end
            ST_RESET: begin
                if (!rst_req) nxt = (conn_q && phy_conn) ? ST_ON : ST_OFF;
            end
            ST_ON: begin
                if (drop)         nxt = ST_OFF;
                else if (rst_req) nxt = ST_RESET;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        enabled   = (state == ST_ON);
        en_toggle = (state == ST_ON) != (nxt == ST_ON);
        state_o   = state;
    end

endmodule

// File: rtl/rootport_csr.sv
module rootport_csr
    import rpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              phy_connected,
    input  logic              phy_overcurrent,
    input  logic [LINE_W-1:0] phy_line,
    input  logic [SPEED_W-1:0] phy_speed,
    output logic              port_power,
    output logic              port_reset,
    output logic              port_suspend,
    output logic              port_resume,
    output logic              port_enabled,
    output logic              port_change_irq
);

    logic               conn_q, oc_q;
    logic [LINE_W-1:0]  line_q;
    logic [SPEED_W-1:0] speed_q;
    logic               conn_toggle, oc_toggle, oc_rise;
    logic               en_toggle;
    port_state_e        fsm_state;
    port_ctl_t          ctl;
    logic [NUM_CHG-1:0] chg_set, chg_clr, chg_flag;

    rpcsr_status_cap #(
        .LINE_W  (LINE_W),
        .SPEED_W (SPEED_W)
    ) u_cap (
        .clk             (clk),
        .rst_n           (rst_n),
        .phy_connected   (phy_connected),
        .phy_overcurrent (phy_overcurrent),
        .phy_line        (phy_line),
        .phy_speed       (phy_speed),
        .conn_q          (conn_q),
        .oc_q            (oc_q),
        .line_q          (line_q),
        .speed_q         (speed_q),
        .conn_toggle     (conn_toggle),
        .oc_toggle       (oc_toggle),
        .oc_rise         (oc_rise)
    );

    rpcsr_port_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req    (ctl.preset),
        .conn_q     (conn_q),
        .phy_conn   (phy_connected),
        .oc_rise    (oc_rise),
        .power_on   (ctl.power),
        .sw_disable (csr_wr & csr_wdata[B_EN]),
        .enabled    (port_enabled),
        .en_toggle  (en_toggle),
        .state_o    (fsm_state)
    );

    // software-owned controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (csr_wr) begin
            ctl.resume  <= csr_wdata[B_RESUME];
            ctl.suspend <= csr_wdata[B_SUSPEND];
            ctl.preset  <= csr_wdata[B_PRESET];
            ctl.power   <= csr_wdata[B_POWER];
        end
    end

    always_comb begin
        chg_set            = '0;
        chg_set[CHG_CONN]  = conn_toggle;
        chg_set[CHG_EN]    = en_toggle;
        chg_set[CHG_OC]    = oc_toggle;
    end

    for (genvar gi = 0; gi < NUM_CHG; gi++) begin : g_chg
        assign chg_clr[gi] = csr_wr & csr_wdata[chg_pos(gi)];
        rpcsr_sticky u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (chg_set[gi]),
            .clr_i  (chg_clr[gi]),
            .flag_o (chg_flag[gi])
        );
    end

    always_comb begin
        csr_rdata = '0;
        csr_rdata[B_CONN]                  = conn_q;
        csr_rdata[B_EN]                    = port_enabled;
        csr_rdata[B_OC]                    = oc_q;
        csr_rdata[B_RESUME]                = ctl.resume;
        csr_rdata[B_SUSPEND]               = ctl.suspend;
        csr_rdata[B_PRESET]                = ctl.preset;
        csr_rdata[B_LINE +: LINE_W]        = line_q;
        csr_rdata[B_POWER]                 = ctl.power;
        csr_rdata[B_SPEED +: SPEED_W]      = conn_q ? speed_q : '0;
        for (int i = 0; i < NUM_CHG; i++) begin
            csr_rdata[chg_pos(i)] = chg_flag[i];
        end
    end

    always_comb begin
        port_power      = ctl.power;
        port_reset      = ctl.preset;
        port_suspend    = ctl.suspend;
        port_resume     = ctl.resume;
        port_change_irq = |chg_flag;
    end

endmodule

// File: rtl/rootport_csr_chk.sv
module rootport_csr_chk
    import rpcsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr,
    input logic [CSR_W-1:0] csr_wdata,
    input logic [CSR_W-1:0] csr_rdata,
    input logic             port_enabled,
    input logic             port_change_irq,
    input port_state_e      state
);

    localparam logic [CSR_W-1:0] RSVD_MASK = 32'hFFF9_E200;

    p_conn_chg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[0] != $past(csr_rdata[0])) |-> csr_rdata[1]);

    p_en_conn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[2] |-> csr_rdata[0]);

    p_sw_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata[2] && port_enabled) |=> (!port_enabled && csr_rdata[3]));

    p_oc_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[4]) |-> !port_enabled);

    p_speed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[0] |-> (csr_rdata[18:17] == 2'b00));

    p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata != '0) |=> ((csr_rdata & RSVD_MASK) == '0));

    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[1] || csr_rdata[3] || csr_rdata[5]) |-> port_change_irq);

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_rdata[1] || csr_rdata[3] || csr_rdata[5]) |-> !port_change_irq);

    p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_enabled) |-> ($past(state) == ST_RESET && csr_rdata[3]));

    p_detach_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(csr_rdata[0]) && $past(port_enabled)) |->
            (!port_enabled && csr_rdata[1] && csr_rdata[3]));

    p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !csr_wdata[1] && csr_rdata[1]) |=> csr_rdata[1]);

endmodule

bind rootport_csr rootport_csr_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .csr_wr          (csr_wr),
    .csr_wdata       (csr_wdata),
    .csr_rdata       (csr_rdata),
    .port_enabled    (port_enabled),
    .port_change_irq (port_change_irq),
    .state           (fsm_state)
);

// File: tb/sim_rootport_csr.sv
`timescale 1ns/1ps
module sim_rootport_csr;

    localparam logic [31:0] PWR  = 32'h0000_1000;
    localparam logic [31:0] PRST = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        phy_connected = 1'b0;
    logic        phy_overcurrent = 1'b0;
    logic [1:0]  phy_line = '0;
    logic [1:0]  phy_speed = '0;
    logic        port_power, port_reset, port_suspend, port_resume;
    logic        port_enabled, port_change_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rootport_csr u0 (
        .clk (clk), .rst_n (rst_n), .csr_wr (csr_wr), .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata), .phy_connected (phy_connected),
        .phy_overcurrent (phy_overcurrent), .phy_line (phy_line),
        .phy_speed (phy_speed), .port_power (port_power), .port_reset (port_reset),
        .port_suspend (port_suspend), .port_resume (port_resume),
        .port_enabled (port_enabled), .port_change_irq (port_change_irq)
    );

    // behavioural reference: 0 off, 1 in reset, 2 enabled
    int   m_st;
    bit   m_conn, m_cc, m_ec, m_oc, m_occ, m_res, m_sus, m_prst, m_pwr;
    bit [1:0] m_line, m_spd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_conn = 0; m_cc = 0; m_ec = 0; m_oc = 0; m_occ = 0;
            m_res = 0; m_sus = 0; m_prst = 0; m_pwr = 0; m_line = 0; m_spd = 0;
        end else begin
            int  n;
            bit  was_on, oc_up;
            was_on = (m_st == 2);
            oc_up  = phy_overcurrent && !m_oc;
            n = m_st;
            if (m_st == 0) begin
                if (m_prst) n = 1;
            end else if (m_st == 1) begin
                if (!m_prst) n = (m_conn && phy_connected) ? 2 : 0;
            end else begin
                if (!phy_connected || oc_up || !m_pwr || (csr_wr && csr_wdata[2])) n = 0;
                else if (m_prst) n = 1;
            end
            if (m_conn != phy_connected) m_cc = 1;
            else if (csr_wr && csr_wdata[1]) m_cc = 0;
            if (was_on != (n == 2)) m_ec = 1;
            else if (csr_wr && csr_wdata[3]) m_ec = 0;
            if (m_oc != phy_overcurrent) m_occ = 1;
            else if (csr_wr && csr_wdata[5]) m_occ = 0;
            m_st = n;
            m_conn = phy_connected; m_oc = phy_overcurrent;
            m_line = phy_line; m_spd = phy_speed;
            if (csr_wr) begin
                m_res = csr_wdata[6]; m_sus = csr_wdata[7];
                m_prst = csr_wdata[8]; m_pwr = csr_wdata[12];
            end
        end
    end

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[0] = m_conn; w[1] = m_cc; w[2] = (m_st == 2); w[3] = m_ec;
        w[4] = m_oc; w[5] = m_occ; w[6] = m_res; w[7] = m_sus; w[8] = m_prst;
        w[11:10] = m_line; w[12] = m_pwr;
        w[18:17] = m_conn ? m_spd : 2'b00;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] e;
            e = model_word();
            chk("R2 attach bits",   csr_rdata & 32'h3,        e & 32'h3);
            chk("R3 enable bits",   csr_rdata & 32'hC,        e & 32'hC);
            chk("R5 overcur bits",  csr_rdata & 32'h30,       e & 32'h30);
            chk("R6 control bits",  csr_rdata & 32'h11C0,     e & 32'h11C0);
            chk("R7 line/speed/rsvd", csr_rdata & ~32'h11FF, e & ~32'h11FF);
            chk("R8 irq", {31'b0, port_change_irq}, {31'b0, (m_cc | m_ec | m_occ)});
            chk("R6 outputs", {28'b0, port_power, port_reset, port_suspend, port_resume},
                {28'b0, m_pwr, m_prst, m_sus, m_res});
            chk("R3 port_enabled", {31'b0, port_enabled}, {31'b0, (m_st == 2)});
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_wr(input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic bring_up();
        do_wr(PWR | PRST);
        idle(2);
        do_wr(PWR);
        idle(3);
        do_wr(PWR | 32'h8);
        idle(1);
    endtask

    initial begin
        idle(3);
        chk("R1 reset word", csr_rdata, 32'h0);
        chk("R1 reset outputs", {26'b0, port_power, port_reset, port_suspend,
            port_resume, port_enabled, port_change_irq}, 32'h0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 after release", csr_rdata, 32'h0);

        phy_connected = 1; phy_speed = 2'b01; phy_line = 2'b01;
        idle(2);
        chk("R2 attach seen", csr_rdata & 32'h3, 32'h3);
        chk("R8 irq on attach", {31'b0, port_change_irq}, 32'h1);
        chk("R7 speed full", {30'b0, csr_rdata[18:17]}, 32'h1);

        do_wr(32'h1);
        idle(2);
        chk("R11 zero keeps flag", {31'b0, csr_rdata[1]}, 32'h1);
        chk("R2 bit0 read-only", {31'b0, csr_rdata[0]}, 32'h1);
        do_wr(32'h2);
        idle(1);
        chk("R2 w1c clears", {31'b0, csr_rdata[1]}, 32'h0);
        chk("R8 irq quiet", {31'b0, port_change_irq}, 32'h0);

        do_wr(PWR | PRST);
        idle(3);
        chk("R6 reset drive", {30'b0, port_reset, port_enabled}, 32'h2);
        do_wr(PWR);
        idle(3);
        chk("R9 release enables", {30'b0, port_enabled, csr_rdata[3]}, 32'h3);
        do_wr(PWR | 32'h8);
        idle(2);

        do_wr(PWR);
        idle(2);
        chk("R4 write 0 keeps enable", {31'b0, port_enabled}, 32'h1);
        do_wr(PWR | 32'h4);
        idle(2);
        chk("R4 write 1 disables", {30'b0, port_enabled, csr_rdata[3]}, 32'h1);
        do_wr(PWR | 32'h8);

        bring_up();
        phy_overcurrent = 1;
        idle(2);
        chk("R5 overcurrent disables", {29'b0, csr_rdata[5], csr_rdata[4], port_enabled}, 32'h6);
        phy_overcurrent = 0;
        idle(2);
        do_wr(PWR | 32'h28);
        idle(2);
        chk("R5 flag cleared", {31'b0, csr_rdata[5]}, 32'h0);

        bring_up();
        do_wr(PWR | PRST);
        idle(3);
        chk("R9 reset while on", {30'b0, port_enabled, csr_rdata[3]}, 32'h1);
        do_wr(PWR);
        idle(3);
        do_wr(PWR | 32'h8);
        do_wr(PWR | 32'hC0);
        idle(2);
        chk("R6 suspend resume", {30'b0, port_suspend, port_resume}, 32'h3);
        do_wr(PWR);
        idle(1);
        do_wr(32'h0);
        idle(2);
        chk("R6 power off disables", {31'b0, port_enabled}, 32'h0);
        do_wr(PWR | 32'h8);

        bring_up();
        phy_speed = 2'b10; phy_line = 2'b10;
        idle(2);
        phy_connected = 0;
        idle(1);
        chk("R10 detach same edge", csr_rdata & 32'hF, 32'hA);
        chk("R7 speed masked", {30'b0, csr_rdata[18:17]}, 32'h0);
        do_wr(PWR | 32'hA);

        do_wr(PWR | PRST);
        idle(2);
        do_wr(PWR);
        idle(3);
        chk("R9 no device stays off", {30'b0, port_enabled, csr_rdata[3]}, 32'h0);

        @(negedge clk);
        phy_connected = 1; csr_wr = 1; csr_wdata = PWR | 32'h2;
        @(negedge clk);
        csr_wr = 0; csr_wdata = '0;
        chk("R2 set beats clear", {31'b0, csr_rdata[1]}, 32'h1);

        do_wr(PWR | 32'hFFF9_E200);
        idle(2);
        chk("R7 reserved zero", csr_rdata & 32'hFFF9_E200, 32'h0);
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule